// File: doc/BRIEF.md
# Multi-Mode Quadrature Input Decoder

This block sits between the raw encoder lines of one counter channel (phase A, phase B and an index mark) and the counting register that follows it. It cleans the three lines with a two-stage synchronizer and a sampled glitch filter. The filter's sample rate is set by an 8-bit divider. The cleaned phases are then decoded into a single-cycle count strobe and a direction bit.

A 2-bit mode selects the decoding at run time: pulse/direction, or quadrature at one, two or four counts per cycle. In the x1 setting the edge of A that counts depends on the direction of travel. When A and B change on the same filter sample, the transition is illegal, and a sticky noise flag records it until an explicit clear.

The index line is qualified by a selectable polarity and yields an index event. In a quadrature mode it may instead be synchronized to the count edges. That synchronous gating is refused in pulse/direction mode.

Top module: `qdec_top`

## Requirements
- R1: With mode = 2'b00 (pulse/direction), a count occurs only on a rising transition of filtered A. The direction is the B level at that moment (B = 1 counts up). Transitions of B never count.
- R2: With mode = 2'b01 (x1), only transitions of A that happen while B is low count: a rising A counts up, and a falling A counts down.
- R3: With mode = 2'b10 (x2), every transition of A counts and no transition of B counts. The direction is up when the new A level differs from B.
- R4: With mode = 2'b11 (x4), every transition of exactly one of A or B counts. Forward travel follows the (A,B) order 00, 10, 11, 01, and forward travel counts up.
- R5: `count_up` holds the direction of the latest counted transition, with 1 meaning up and 0 meaning down; it is 1 after reset. Each counted transition gives exactly one single-cycle `count_stb` pulse, and `count_stb`, `index_evt` and `noise_err` are 0 after reset.
- R6: Each input passes two synchronizer flops. A new filtered level is taken only when two consecutive filter samples agree, so a one-clock glitch is never counted.
- R7: The filter samples once every `prescale`+1 clocks, where `prescale` is 8 bits and 0 means every clock. A pulse shorter than `prescale`+1 clocks produces no count.
- R8: In a quadrature mode, a filter sample in which A and B both change produces no count and sets `noise_err`. The flag stays set until `err_clear` is pulsed.
- R9: While `ab_enable` is low no `count_stb` occurs, but filtering continues. After re-enabling, the next single step counts exactly once.
- R10: `idx_polarity` = 1 makes a high index active, and 0 makes a low index active. In non-synchronous operation `index_evt` pulses once when the qualified index becomes active. With `idx_enable` low, no index event occurs.
- R11: `sync_idx_active` is 1 only when `sync_idx_req` is set and the mode is quadrature. While it is 1, `index_evt` pulses on each counted transition that occurs while the index is active, and not on the index assertion itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Decode mode: 00 pulse/dir, 01 x1, 10 x2, 11 x4 |
| prescale | input | 8 | Filter sample divider; a sample every prescale+1 clocks |
| ab_enable | input | 1 | Allows count strobes when high |
| idx_enable | input | 1 | Allows index events when high |
| idx_polarity | input | 1 | 1 = index active high, 0 = active low |
| sync_idx_req | input | 1 | Requests count-synchronous index operation |
| err_clear | input | 1 | Clears the noise flag |
| in_a | input | 1 | Raw phase A |
| in_b | input | 1 | Raw phase B |
| in_idx | input | 1 | Raw index line |
| count_stb | output | 1 | One-cycle pulse per counted transition |
| count_up | output | 1 | Direction of latest counted transition (1 = up) |
| index_evt | output | 1 | One-cycle index event |
| noise_err | output | 1 | Sticky illegal-transition flag |
| sync_idx_active | output | 1 | Count-synchronous index operation in force |

## Verification
The bench walks random quadrature sequences in both directions under random modes and divider settings. It compares the number of strobes and the final direction against a step-by-step model of the rules. Under that model, a decoder that picks the wrong A edge in x1, or lets B count in x2, shows a wrong strobe count. Directed cases target the filter: a one-clock glitch and a pulse shorter than the sample period must both vanish, which a filter that ignores the divider or trusts a single sample would count. Further cases check that a simultaneous A/B change sets a flag that survives until cleared, and that the disable input stops strobes without leaving a stale state that fakes a count on re-enable. Finally, synchronous index gating must vanish in pulse/direction mode and must fire only with count edges.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

   typedef enum logic [1:0] {
      QD_PULSE_DIR = 2'b00,
      QD_X1        = 2'b01,
      QD_X2        = 2'b10,
      QD_X4        = 2'b11
   } qd_mode_e;

   localparam int unsigned LINE_A   = 0;
   localparam int unsigned LINE_B   = 1;
   localparam int unsigned LINE_IDX = 2;
   localparam int unsigned N_LINES  = 3;

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("qdec_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("qdec_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q[0] <= '0;
      end else begin
         stage_q[0] <= d_i;
      end
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q[s] <= '0;
            end else begin
               stage_q[s] <= stage_q[s-1];
            end
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/qdec_filter.sv
module qdec_filter #(
   parameter int unsigned WIDTH      = 3,
   parameter int unsigned PRESCALE_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [PRESCALE_W-1:0] prescale_i,
   input  logic [WIDTH-1:0]      d_i,
   output logic [WIDTH-1:0]      q_o,
   output logic                  tick_o
);

   generate
      if (PRESCALE_W < 1) begin : g_bad_psw
         $error("qdec_filter: PRESCALE_W must be at least 1");
      end
   endgenerate

   logic [PRESCALE_W-1:0] div_q;
   logic                  tick;
   logic [WIDTH-1:0]      samp_q;
   logic [WIDTH-1:0]      filt_q;

   assign tick = (div_q >= prescale_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (tick) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_q <= '0;
      end else if (tick) begin
         samp_q <= d_i;
      end
   end

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_line
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               filt_q[i] <= 1'b0;
            end else if (tick && (d_i[i] == samp_q[i])) begin
               filt_q[i] <= d_i[i];
            end
         end
      end
   endgenerate

   assign q_o    = filt_q;
   assign tick_o = tick;

   // R6
   filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(filt_q))
      else $error("filtered level moved without a sample tick");

   // R7
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (prescale_i != '0)) |=> ((prescale_i == '0) || !tick))
      else $error("sample ticks closer than the divider allows");

endmodule

// File: rtl/qdec_decode.sv
module qdec_decode
   import qdec_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  qd_mode_e mode_i,
   input  logic     a_i,
   input  logic     b_i,
   input  logic     err_clr_i,
   output logic     hit_o,
   output logic     up_o,
   output logic     noise_o
);

   logic a_prev_q, b_prev_q;
   logic a_chg, b_chg, both_chg;
   logic hit, dir;
   logic up_q, noise_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_prev_q <= 1'b0;
         b_prev_q <= 1'b0;
      end else begin
         a_prev_q <= a_i;
         b_prev_q <= b_i;
      end
   end

   assign a_chg    = a_i ^ a_prev_q;
   assign b_chg    = b_i ^ b_prev_q;
   assign both_chg = a_chg & b_chg;

   always_comb begin
      hit = 1'b0;
      dir = 1'b1;
      unique case (mode_i)
         QD_PULSE_DIR: begin
            hit = a_chg & a_i;
            dir = b_i;
         end
         QD_X1: begin
            hit = a_chg & ~b_chg & ~b_i;
            dir = a_i ^ b_i;
         end
         QD_X2: begin
            hit = a_chg & ~b_chg;
            dir = a_i ^ b_i;
         end
         QD_X4: begin
            hit = a_chg ^ b_chg;
            dir = a_chg ? (a_i ^ b_i) : ~(a_i ^ b_i);
         end
         default: begin
            hit = 1'b0;
            dir = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q <= 1'b1;
      end else if (hit) begin
         up_q <= dir;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         noise_q <= 1'b0;
      end else if (both_chg && (mode_i != QD_PULSE_DIR)) begin
         noise_q <= 1'b1;
      end else if (err_clr_i) begin
         noise_q <= 1'b0;
      end
   end

   assign hit_o   = hit;
   assign up_o    = up_q;
   assign noise_o = noise_q;

   // R8
   noise_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (noise_q && !err_clr_i) |=> noise_q)
      else $error("noise flag dropped without a clear");

endmodule

// File: rtl/qdec_top.sv
module qdec_top
   import qdec_pkg::*;
#(
   parameter int unsigned PRESCALE_W  = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            mode,
   input  logic [PRESCALE_W-1:0] prescale,
   input  logic                  ab_enable,
   input  logic                  idx_enable,
   input  logic                  idx_polarity,
   input  logic                  sync_idx_req,
   input  logic                  err_clear,
   input  logic                  in_a,
   input  logic                  in_b,
   input  logic                  in_idx,
   output logic                  count_stb,
   output logic                  count_up,
   output logic                  index_evt,
   output logic                  noise_err,
   output logic                  sync_idx_active
);

   localparam int unsigned LINES = N_LINES;

   qd_mode_e          mode_e;
   logic [LINES-1:0]  raw_lines, sync_lines, filt_lines;
   logic              tick_unused;
   logic              hit, up, noise;
   logic              idx_act, idx_act_prev_q;
   logic              stb_q, evt_q, sync_q;
   logic              evt_next;

   assign mode_e = qd_mode_e'(mode);

   assign raw_lines[LINE_A]   = in_a;
   assign raw_lines[LINE_B]   = in_b;
   assign raw_lines[LINE_IDX] = in_idx;

   qdec_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_lines),
      .q_o   (sync_lines)
   );

   qdec_filter #(.WIDTH(LINES), .PRESCALE_W(PRESCALE_W)) u_filter (
      .clk        (clk),
      .rst_n      (rst_n),
      .prescale_i (prescale),
      .d_i        (sync_lines),
      .q_o        (filt_lines),
      .tick_o     (tick_unused)
   );

   qdec_decode u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (mode_e),
      .a_i       (filt_lines[LINE_A]),
      .b_i       (filt_lines[LINE_B]),
      .err_clr_i (err_clear),
      .hit_o     (hit),
      .up_o      (up),
      .noise_o   (noise)
   );

   assign idx_act = idx_polarity ? filt_lines[LINE_IDX] : ~filt_lines[LINE_IDX];

   always_comb begin
      if (!idx_enable) begin
         evt_next = 1'b0;
      end else if (sync_q) begin
         evt_next = hit & idx_act;
      end else begin
         evt_next = idx_act & ~idx_act_prev_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_act_prev_q <= 1'b0;
         stb_q          <= 1'b0;
         evt_q          <= 1'b0;
         sync_q         <= 1'b0;
      end else begin
         idx_act_prev_q <= idx_act;
         stb_q          <= hit & ab_enable;
         evt_q          <= evt_next;
         sync_q         <= sync_idx_req & (mode_e != QD_PULSE_DIR);
      end
   end

   assign count_stb       = stb_q;
   assign count_up        = up;
   assign index_evt       = evt_q;
   assign noise_err       = noise;
   assign sync_idx_active = sync_q;

   // R9
   no_stb_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ab_enable |=> !count_stb)
      else $error("count strobe while A/B disabled");

   // R11
   sync_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_e == QD_PULSE_DIR) |=> !sync_idx_active)
      else $error("synchronous index in pulse/direction mode");

endmodule

// File: tb/qdec_top_bench.sv
module qdec_top_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode = 2'b11;
   logic [7:0] prescale = 8'd0;
   logic       ab_enable = 1'b1;
   logic       idx_enable = 1'b0;
   logic       idx_polarity = 1'b1;
   logic       sync_idx_req = 1'b0;
   logic       err_clear = 1'b0;
   logic       in_a = 1'b0, in_b = 1'b0, in_idx = 1'b0;
   logic       count_stb, count_up, index_evt, noise_err, sync_idx_active;

   int checks = 0;
   int errors = 0;
   int stb_total = 0;
   int evt_total = 0;
   bit exp_up = 1'b1;

   always #2.5 clk = ~clk;

   qdec_top u_qdec_top (
      .clk(clk), .rst_n(rst_n), .mode(mode), .prescale(prescale),
      .ab_enable(ab_enable), .idx_enable(idx_enable), .idx_polarity(idx_polarity),
      .sync_idx_req(sync_idx_req), .err_clear(err_clear),
      .in_a(in_a), .in_b(in_b), .in_idx(in_idx),
      .count_stb(count_stb), .count_up(count_up), .index_evt(index_evt),
      .noise_err(noise_err), .sync_idx_active(sync_idx_active)
   );

   always @(negedge clk) begin
      if (count_stb) stb_total++;
      if (index_evt) evt_total++;
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   function automatic int hold_len();
      return 4 * (int'(prescale) + 1) + 8;
   endfunction

   task automatic drive_ab(input logic a, input logic b);
      @(posedge clk); #1;
      in_a = a; in_b = b;
      idle(hold_len());
   endtask

   // returns {counted, up} for one transition, from the mode rules R1..R4
   function automatic logic [1:0] step_rule(input logic [1:0] m, input logic oa, input logic ob,
                                            input logic na, input logic nb);
      logic ac, bc;
      ac = oa ^ na; bc = ob ^ nb;
      if (m == 2'b00) return {ac & na, nb};
      if (ac && bc) return 2'b00;
      case (m)
         2'b01: return {ac & ~nb, na ^ nb};
         2'b10: return {ac, na ^ nb};
         default: return {ac | bc, ac ? (na ^ nb) : ~(na ^ nb)};
      endcase
   endfunction

   // forward order of (A,B): 00,10,11,01
   function automatic logic [1:0] gray_ab(input int q);
      case (q & 3)
         0: return 2'b00;
         1: return 2'b10;
         2: return 2'b11;
         default: return 2'b01;
      endcase
   endfunction

   function automatic int ab_to_q(input logic a, input logic b);
      case ({a, b})
         2'b00: return 0;
         2'b10: return 1;
         2'b11: return 2;
         default: return 3;
      endcase
   endfunction

   task automatic walk(input bit fwd, input int n, inout int exp_cnt);
      for (int k = 0; k < n; k++) begin
         int q;
         logic [1:0] nx, r;
         q = ab_to_q(in_a, in_b);
         nx = gray_ab(fwd ? q + 1 : q + 3);
         r = step_rule(mode, in_a, in_b, nx[1], nx[0]);
         if (r[1]) begin
            exp_cnt++;
            exp_up = r[0];
         end
         drive_ab(nx[1], nx[0]);
      end
   endtask

   initial begin : watchdog
      #900us;
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      int base, ebase, exp_cnt;
      void'($urandom(32'h5EED_0042));
      idle(3);
      // R5 reset state
      check("R5 reset count_stb", count_stb, 0);
      check("R5 reset count_up", count_up, 1);
      check("R5 reset noise_err", noise_err, 0);
      check("R5 reset index_evt", index_evt, 0);
      rst_n = 1'b1;
      idle(10);

      // R6 one-clock glitch on A, x4 mode, every-clock sampling
      base = stb_total;
      @(posedge clk); #1; in_a = 1'b1;
      @(posedge clk); #1; in_a = 1'b0;
      idle(20);
      check("R6 glitch rejected", stb_total - base, 0);

      // R7 pulse shorter than the sample period is rejected
      prescale = 8'd9; idle(20);
      base = stb_total;
      @(posedge clk); #1; in_a = 1'b1;
      idle(5); in_a = 1'b0;
      idle(60);
      check("R7 short pulse rejected at prescale 9", stb_total - base, 0);
      prescale = 8'd0; idle(10);
      base = stb_total;
      @(posedge clk); #1; in_a = 1'b1;
      idle(5); in_a = 1'b0;
      idle(20);
      check("R7 same pulse counted twice in x4 at prescale 0", stb_total - base, 2);

      // R8 simultaneous A/B change
      base = stb_total;
      drive_ab(1'b1, 1'b1);
      check("R8 no count on double change", stb_total - base, 0);
      check("R8 noise flag set", noise_err, 1);
      idle(30);
      check("R8 noise flag sticky", noise_err, 1);
      @(posedge clk); #1; err_clear = 1'b1;
      @(posedge clk); #1; err_clear = 1'b0;
      idle(2);
      check("R8 noise flag cleared", noise_err, 0);

      // R9 enable gating
      ab_enable = 1'b0;
      base = stb_total; exp_cnt = 0;
      walk(1'b1, 4, exp_cnt);
      check("R9 no strobes while disabled", stb_total - base, 0);
      ab_enable = 1'b1; idle(4);
      base = stb_total; exp_cnt = 0;
      walk(1'b1, 1, exp_cnt);
      check("R9 single count after re-enable", stb_total - base, 1);
      check("R9 direction follows the step", count_up, exp_up);

      // R10 index polarity, non-synchronous
      idx_enable = 1'b1; idx_polarity = 1'b1; in_idx = 1'b0; idle(20);
      ebase = evt_total;
      in_idx = 1'b1; idle(20);
      check("R10 active-high assertion event", evt_total - ebase, 1);
      in_idx = 1'b0; idle(20);
      check("R10 no event on deassertion", evt_total - ebase, 1);
      in_idx = 1'b1; idle(20);
      idx_polarity = 1'b0; idle(10);
      ebase = evt_total;
      in_idx = 1'b0; idle(20);
      check("R10 active-low assertion event", evt_total - ebase, 1);
      idx_enable = 1'b0; in_idx = 1'b1; idle(20); in_idx = 1'b0; idle(20);
      check("R10 no event when index disabled", evt_total - ebase, 1);

      // R11 synchronous index
      idx_enable = 1'b1; idx_polarity = 1'b1; in_idx = 1'b0;
      mode = 2'b11; sync_idx_req = 1'b1; idle(20);
      check("R11 sync active in x4", sync_idx_active, 1);
      ebase = evt_total;
      in_idx = 1'b1; idle(20);
      check("R11 no event on index assertion", evt_total - ebase, 0);
      exp_cnt = 0; base = stb_total;
      walk(1'b1, 3, exp_cnt);
      check("R11 one event per counted edge", evt_total - ebase, 3);
      in_idx = 1'b0; idle(20);
      ebase = evt_total;
      walk(1'b0, 2, exp_cnt);
      check("R11 no event with index inactive", evt_total - ebase, 0);
      mode = 2'b00; idle(4);
      check("R11 sync refused in pulse/direction", sync_idx_active, 0);
      ebase = evt_total;
      in_idx = 1'b1; idle(20);
      check("R11 non-sync event in pulse/direction", evt_total - ebase, 1);
      sync_idx_req = 1'b0; idx_enable = 1'b0; in_idx = 1'b0; idle(20);

      // R1..R5 random mode walks
      for (int it = 0; it < 24; it++) begin
         int n;
         bit fwd;
         mode = 2'($urandom % 4);
         prescale = 8'($urandom % 6);
         fwd = 1'($urandom % 2);
         n = 1 + int'($urandom % 10);
         idle(hold_len());
         if (mode == 2'b00) begin
            drive_ab(1'b0, fwd);
            base = stb_total;
            for (int p = 0; p < n; p++) begin
               drive_ab(1'b1, fwd);
               drive_ab(1'b0, fwd);
            end
            exp_up = fwd;
            check("R1 pulse count", stb_total - base, n);
            check("R1 direction from B", count_up, exp_up);
         end else begin
            base = stb_total; exp_cnt = 0;
            walk(fwd, n, exp_cnt);
            if (mode == 2'b01) begin
               check("R2 x1 count", stb_total - base, exp_cnt);
            end else if (mode == 2'b10) begin
               check("R3 x2 count", stb_total - base, exp_cnt);
            end else begin
               check("R4 x4 count", stb_total - base, exp_cnt);
            end
            check("R5 direction", count_up, exp_up);
         end
      end
      check("R8 no noise during legal walks", noise_err, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule